// File: doc/BRIEF.md
# Thread Criticality Steal Predictor

This block sits next to a shared second-level cache controller in a multi-core chip. For every core it keeps a saturating criticality score that grows whenever that core reports a cache miss. A second-level miss costs far more than a first-level miss, so it carries ten times the weight. A core that misses often scores high. Such a core is running slowly and is likely to be the one that holds the rest back.

When a core runs out of work, it raises a steal request. The block then picks the core with the highest score, leaving out the requester, and names it as the victim. The requester should take a task from the victim's queue. A programmable period clears every score at a regular rhythm, so the ranking reflects recent behaviour only. Writing a period of zero turns the clearing off.

Top module: `crit_steal_unit`

## Requirements
- R1: After synchronous reset, every score is zero, the clearing period is zero (disabled), `resp_valid_o` is 0 and no `steal_ready_o` bit is set.
- R2: A cycle with `l1_miss_i[c]` high adds 1 to core c's score. A cycle with neither miss input high for that core leaves the score unchanged.
- R3: A cycle with `l2_miss_i[c]` high adds 10 to core c's score. When both miss inputs are high in the same cycle, the score grows by 11.
- R4: Each score is 14 bits wide and saturates at 16383 instead of wrapping.
- R5: Writing B through `bound_we_i`/`bound_data_i` on clock edge E clears all scores at edges E+B, E+2B, and so on. A miss sampled on a clearing edge is dropped. B = 0 never clears.
- R6: A steal answer names the core with the largest score, excluding the requester. On equal scores, the lowest-numbered core wins.
- R7: If every score other than the requester's is zero, the answer has `resp_found_o` = 0 and `resp_victim_o` = 0.
- R8: `steal_ready_o` is one-hot on the lowest-numbered core that asserts `steal_req_i`. The answer for the accepted core (`resp_valid_o` = 1, `resp_core_o` = requester) appears on the next clock edge. A cycle with no request yields `resp_valid_o` = 0 on the next edge.
- R9: Miss events from several cores in the same cycle are all counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_miss_i | input | NCORES | Per-core first-level miss strobe (instruction or data) |
| l2_miss_i | input | NCORES | Per-core second-level miss strobe |
| steal_req_i | input | NCORES | Per-core steal request, held until ready |
| steal_ready_o | output | NCORES | One-hot acceptance of a steal request |
| bound_we_i | input | 1 | Write strobe for the clearing period |
| bound_data_i | input | BOUND_W | New clearing period in cycles, 0 = off |
| resp_valid_o | output | 1 | Steal answer present |
| resp_core_o | output | $clog2(NCORES) | Core the answer belongs to |
| resp_found_o | output | 1 | A victim was found |
| resp_victim_o | output | $clog2(NCORES) | Victim core index, 0 when none |

## Verification
A miss changes a score on the edge that samples it. A steal answer becomes visible one edge after its request is accepted. The bench drives inputs on the falling edge and reads the answer at the next falling edge, one registered stage later. Readiness is combinational, so it is checked 1 ns after the request is driven. For the clearing period, the bench counts falling edges from the write so that one event lands exactly on the clearing edge (E+B) and the next lands one edge after it. Scores cannot be read directly; they are inferred from argmax answers, using pairs of cores that are brought level and then pushed one step apart.

// File: rtl/crit_pkg.sv
`timescale 1ns/1ps
package crit_pkg;
  // default sizes and event weights shared by the predictor modules
  localparam int unsigned DEF_CNT_W   = 14;
  localparam int unsigned DEF_BOUND_W = 24;
  localparam int unsigned DEF_L1_WT   = 1;
  localparam int unsigned DEF_L2_WT   = 10;
endpackage

// File: rtl/crit_counter.sv
`timescale 1ns/1ps
module crit_counter #(
  parameter int unsigned CNT_W = crit_pkg::DEF_CNT_W,
  parameter int unsigned L1_WT = crit_pkg::DEF_L1_WT,
  parameter int unsigned L2_WT = crit_pkg::DEF_L2_WT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             l1_ev_i,
  input  logic             l2_ev_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W:0]   MAXV    = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] MAXC    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] L1_ROOM = MAXC - CNT_W'(L1_WT);
  localparam logic [CNT_W-1:0] L2_ROOM = MAXC - CNT_W'(L2_WT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   inc;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    inc = '0;
    if (l1_ev_i) inc = inc + (CNT_W+1)'(L1_WT);
    if (l2_ev_i) inc = inc + (CNT_W+1)'(L2_WT);
    sum = {1'b0, cnt_q} + inc;
    nxt = (sum > MAXV) ? MAXC : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)           cnt_q <= '0;
    else if (l1_ev_i || l2_ev_i) cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && cnt_q == MAXC) |=> (cnt_q == MAXC));
  assert_l1_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && l1_ev_i && !l2_ev_i && cnt_q <= L1_ROOM) |=> (cnt_q == $past(cnt_q) + CNT_W'(L1_WT)));
  assert_l2_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && l2_ev_i && !l1_ev_i && cnt_q <= L2_ROOM) |=> (cnt_q == $past(cnt_q) + CNT_W'(L2_WT)));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !l1_ev_i && !l2_ev_i) |=> $stable(cnt_q));
endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer #(
  parameter int unsigned BOUND_W = crit_pkg::DEF_BOUND_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic [BOUND_W-1:0] wdata_i,
  output logic               clr_o
);
  logic [BOUND_W-1:0] bound_q;
  logic [BOUND_W-1:0] tick_q;
  logic               at_end;

  assign at_end = (bound_q != '0) && (tick_q == bound_q - BOUND_W'(1));
  assign clr_o  = at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      bound_q <= '0;
      tick_q  <= '0;
    end else if (we_i) begin
      bound_q <= wdata_i;
      tick_q  <= '0;
    end else if (bound_q != '0) begin
      tick_q <= at_end ? '0 : tick_q + BOUND_W'(1);
    end
  end

  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (tick_q == '0));
  assert_tick_range_R5: assert property (@(posedge clk) disable iff (rst)
    (bound_q != '0) |-> (tick_q < bound_q));
endmodule

// File: rtl/steal_arbiter.sv
`timescale 1ns/1ps
module steal_arbiter #(
  parameter int unsigned NCORES = 4,
  localparam int unsigned IDW = $clog2(NCORES > 1 ? NCORES : 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCORES-1:0] req_i,
  output logic [NCORES-1:0] grant_o,
  output logic              any_o,
  output logic [IDW-1:0]    id_o
);
  // lowest set bit wins
  assign grant_o = req_i & (~req_i + NCORES'(1));
  assign any_o   = |req_i;

  always_comb begin
    id_o = '0;
    for (int i = NCORES - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = IDW'(i);
    end
  end

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o) && ((grant_o & ~req_i) == '0) && (any_o == (grant_o != '0)));
endmodule

// File: rtl/victim_scan.sv
`timescale 1ns/1ps
module victim_scan #(
  parameter int unsigned NCORES = 4,
  parameter int unsigned CNT_W  = crit_pkg::DEF_CNT_W,
  localparam int unsigned IDW = $clog2(NCORES > 1 ? NCORES : 2)
) (
  input  logic [NCORES-1:0][CNT_W-1:0] cnt_i,
  input  logic [IDW-1:0]               excl_i,
  output logic [IDW-1:0]               victim_o,
  output logic                         found_o
);
  logic [CNT_W-1:0] best_v;
  logic [CNT_W-1:0] cur_v;

  always_comb begin
    best_v   = '0;
    victim_o = '0;
    for (int i = 0; i < NCORES; i++) begin
      cur_v = (IDW'(i) == excl_i) ? '0 : cnt_i[i];
      // strict compare keeps the lowest index on ties and never picks a zero
      if (cur_v > best_v) begin
        best_v   = cur_v;
        victim_o = IDW'(i);
      end
    end
    found_o = (best_v != '0);
  end
endmodule

// File: rtl/crit_steal_unit.sv
`timescale 1ns/1ps
module crit_steal_unit #(
  parameter int unsigned NCORES  = 4,
  parameter int unsigned CNT_W   = crit_pkg::DEF_CNT_W,
  parameter int unsigned BOUND_W = crit_pkg::DEF_BOUND_W,
  parameter int unsigned L1_WT   = crit_pkg::DEF_L1_WT,
  parameter int unsigned L2_WT   = crit_pkg::DEF_L2_WT,
  localparam int unsigned IDW = $clog2(NCORES > 1 ? NCORES : 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCORES-1:0]  l1_miss_i,
  input  logic [NCORES-1:0]  l2_miss_i,
  input  logic [NCORES-1:0]  steal_req_i,
  output logic [NCORES-1:0]  steal_ready_o,
  input  logic               bound_we_i,
  input  logic [BOUND_W-1:0] bound_data_i,
  output logic               resp_valid_o,
  output logic [IDW-1:0]     resp_core_o,
  output logic               resp_found_o,
  output logic [IDW-1:0]     resp_victim_o
);
  logic                         clr;
  logic [NCORES-1:0][CNT_W-1:0] cnt;
  logic [NCORES-1:0]            grant;
  logic                         gnt_any;
  logic [IDW-1:0]               gnt_id;
  logic [IDW-1:0]               scan_victim;
  logic                         scan_found;

  interval_timer #(.BOUND_W(BOUND_W)) u_timer (
    .clk(clk), .rst(rst), .we_i(bound_we_i), .wdata_i(bound_data_i), .clr_o(clr)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    crit_counter #(.CNT_W(CNT_W), .L1_WT(L1_WT), .L2_WT(L2_WT)) u_cnt (
      .clk(clk), .rst(rst), .clr_i(clr),
      .l1_ev_i(l1_miss_i[c]), .l2_ev_i(l2_miss_i[c]), .cnt_o(cnt[c])
    );
  end

  steal_arbiter #(.NCORES(NCORES)) u_arb (
    .clk(clk), .rst(rst), .req_i(steal_req_i),
    .grant_o(grant), .any_o(gnt_any), .id_o(gnt_id)
  );

  victim_scan #(.NCORES(NCORES), .CNT_W(CNT_W)) u_scan (
    .cnt_i(cnt), .excl_i(gnt_id), .victim_o(scan_victim), .found_o(scan_found)
  );

  assign steal_ready_o = grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid_o  <= 1'b0;
      resp_core_o   <= '0;
      resp_found_o  <= 1'b0;
      resp_victim_o <= '0;
    end else begin
      resp_valid_o  <= gnt_any;
      resp_core_o   <= gnt_id;
      resp_found_o  <= gnt_any && scan_found;
      resp_victim_o <= (gnt_any && scan_found) ? scan_victim : '0;
    end
  end

  assert_resp_due_R8: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |=> (resp_valid_o && resp_core_o == $past(gnt_id)));
  assert_resp_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (steal_req_i == '0) |=> !resp_valid_o);
  assert_not_self_R6: assert property (@(posedge clk) disable iff (rst)
    resp_found_o |-> (resp_valid_o && resp_victim_o != resp_core_o));
  assert_none_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !resp_found_o |-> (resp_victim_o == '0));
endmodule

// File: tb/sim_crit_steal_unit.sv
`timescale 1ns/1ps
module sim_crit_steal_unit;
  localparam int N  = 4;
  localparam int BW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  l1 = '0, l2 = '0, req = '0, ready;
  logic          bwe = 1'b0;
  logic [BW-1:0] bdata = '0;
  logic          rvalid, rfound;
  logic [1:0]    rcore, rvictim;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  crit_steal_unit u0 (
    .clk(clk), .rst(rst), .l1_miss_i(l1), .l2_miss_i(l2),
    .steal_req_i(req), .steal_ready_o(ready),
    .bound_we_i(bwe), .bound_data_i(bdata),
    .resp_valid_o(rvalid), .resp_core_o(rcore),
    .resp_found_o(rfound), .resp_victim_o(rvictim)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; l1 = '0; l2 = '0; req = '0; bwe = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // one cycle of miss strobes, returns at the next falling edge
  task automatic ev(input logic [N-1:0] a, input logic [N-1:0] b);
    l1 = a; l2 = b;
    @(negedge clk);
    l1 = '0; l2 = '0;
  endtask

  task automatic write_bound(input int v);
    bwe = 1'b1; bdata = BW'(v);
    @(negedge clk);
    bwe = 1'b0;
  endtask

  task automatic steal(input int core, input logic exp_found, input int exp_victim, input string tag);
    req = N'(1) << core;
    #1;
    check({tag, " ready"}, 32'(ready), 32'(N'(1) << core));
    @(negedge clk);
    req = '0;
    check({tag, " valid"}, 32'(rvalid), 1);
    check({tag, " core"},  32'(rcore), 32'(core));
    check({tag, " found"}, 32'(rfound), 32'(exp_found));
    check({tag, " victim"}, 32'(rvictim), 32'(exp_victim));
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 valid after reset", 32'(rvalid), 0);
    check("R1 ready after reset", 32'(ready), 0);
    steal(0, 1'b0, 0, "R1 zero scores");
    repeat (120) @(negedge clk);
    l1 = 4'b0010; @(negedge clk); l1 = '0;
    steal(0, 1'b1, 1, "R1 period off after reset");
  endtask

  task automatic t_l1_weights();
    do_reset();
    ev(4'b0110, 4'b0000);                  // core1 +1, core2 +1 (R9)
    for (int k = 0; k < 8; k++) ev(4'b0010, 4'b0000);   // core1 = 9
    ev(4'b0000, 4'b0000);
    // core2 needs +9 more to reach 10 -> use one L2 on a fresh core instead
    do_reset();
    for (int k = 0; k < 9; k++) ev(4'b0010, 4'b0000);   // core1 = 9
    ev(4'b0000, 4'b0100);                  // core2 = 10
    steal(0, 1'b1, 2, "R3 l2 worth ten beats nine l1");
    ev(4'b0010, 4'b0000);                  // core1 = 10
    steal(0, 1'b1, 1, "R6 tie goes to lower core");
    ev(4'b0100, 4'b0000);                  // core2 = 11
    steal(0, 1'b1, 2, "R2 single l1 step");
    steal(3, 1'b1, 2, "R2 idle cycles hold score");
  endtask

  task automatic t_both_levels();
    do_reset();
    ev(4'b0001, 4'b0001);                  // core0 = 11
    for (int k = 0; k < 11; k++) ev(4'b1000, 4'b0000);  // core3 = 11
    steal(1, 1'b1, 0, "R3 both misses add eleven");
    steal(0, 1'b1, 3, "R6 requester excluded");
    ev(4'b1000, 4'b0000);                  // core3 = 12
    steal(1, 1'b1, 3, "R3 eleven plus one exceeded");
  endtask

  task automatic t_multi();
    do_reset();
    ev(4'b1111, 4'b0000);
    steal(0, 1'b1, 1, "R9 all cores counted, req0");
    steal(1, 1'b1, 0, "R9 all cores counted, req1");
    ev(4'b0000, 4'b1100);                  // core2 = core3 = 11
    steal(0, 1'b1, 2, "R9 parallel l2 events");
    ev(4'b1000, 4'b0000);
    steal(0, 1'b1, 3, "R9 core3 ahead");
  endtask

  task automatic t_sat();
    do_reset();
    for (int k = 0; k < 1639; k++) ev(4'b0000, (k < 1638) ? 4'b0011 : 4'b0001);
    // core0 saturated at 16383, core1 = 16380
    ev(4'b0010, 4'b0000); ev(4'b0010, 4'b0000); ev(4'b0010, 4'b0000);  // core1 = 16383
    steal(2, 1'b1, 0, "R4 saturated tie to lower core");
    steal(1, 1'b1, 0, "R4 no wrap on core0");
    ev(4'b0011, 4'b0011);
    steal(2, 1'b1, 0, "R4 hold at max under more misses");
  endtask

  task automatic t_none();
    do_reset();
    ev(4'b0100, 4'b0100);
    steal(2, 1'b0, 0, "R7 only requester nonzero");
    steal(1, 1'b1, 2, "R7 other requester finds it");
  endtask

  task automatic t_interval();
    do_reset();
    write_bound(50);                       // sampled on edge E
    for (int k = 0; k < 5; k++) ev(4'b0010, 4'b0000);   // edges E+1..E+5
    repeat (44) @(negedge clk);
    ev(4'b0100, 4'b0000);                  // lands on edge E+50: dropped
    steal(0, 1'b0, 0, "R5 period clear and dropped event");
    ev(4'b1000, 4'b0000);                  // edge E+52: counted
    steal(0, 1'b1, 3, "R5 event after clear counted");
    write_bound(0);
    ev(4'b0010, 4'b0000);
    repeat (150) @(negedge clk);
    steal(0, 1'b1, 1, "R5 zero period disables clearing");
  endtask

  task automatic t_ready();
    do_reset();
    ev(4'b0001, 4'b0000);
    req = 4'b1010;
    #1;
    check("R8 ready picks lowest", 32'(ready), 32'(4'b0010));
    @(negedge clk);
    check("R8 response next edge valid", 32'(rvalid), 1);
    check("R8 response core", 32'(rcore), 1);
    check("R8 response victim", 32'(rvictim), 0);
    req = 4'b1000;
    #1;
    check("R8 stalled core now ready", 32'(ready), 32'(4'b1000));
    @(negedge clk);
    req = '0;
    check("R8 second response core", 32'(rcore), 3);
    check("R8 second response found", 32'(rfound), 1);
    @(negedge clk);
    check("R8 no request no response", 32'(rvalid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 act=%0d exp=%0d", 150000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_l1_weights();
    t_both_levels();
    t_multi();
    t_sat();
    t_none();
    t_interval();
    t_ready();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule